// File: doc/BRIEF.md
# Three-Channel Prescaled Timer Counter

This block holds three independent up-counting timer channels behind a small register bus. The bus has an address, a write enable, a read strobe, write data and read data. Each channel counts input ticks. A tick comes either from the core clock or from a per-channel external enable input. The tick can pass through a power-of-two prescaler before it advances the count. A channel runs free and wraps at its all-ones value, or in interval mode it wraps after reaching a programmed limit.

Each channel latches its wrap events in a status register that clears when it is read. It drives its own interrupt line, which is the status bits gated by an enable register. Software typically uses one channel as a free-running time base and another as a periodic or one-shot event source. The counter width is a parameter and takes the value 16 or 32.

Register offsets for channel 0: clock config 0x00, run control 0x0C, count 0x18, limit 0x24, event status 0x54, event enable 0x60. Channel k uses each offset plus 4·k.

Top module: `tri_timer`

## Requirements
- R1: After reset every register of every channel reads 0, except run control, which reads 0x01 (stopped). All irq lines are low.
- R2: A register of channel k answers at its channel-0 offset plus 4·k. Read data appears on bus_rdata on the cycle after the read strobe and holds until the next strobe. An unmapped address reads 0. A write to the count register has no effect.
- R3: With run control bit 0 clear, the count rises by one on each tick. With bit 0 set, the count holds its value.
- R4: Writing run control with bit 4 set zeroes the count and the prescaler phase at that write's clock edge. Bit 4 always reads back as 0.
- R5: With clock config bit 0 set, the count advances once per 2^(N+1) ticks, where N is clock config bits 4:1.
- R6: With clock config bit 5 set, a tick is a cycle with ext_tick[k] high. With bit 5 clear, every clock cycle is a tick.
- R7: With run control bit 1 set, a step taken while the count equals the limit returns the count to 0. Event status bit 0 is set at that same edge.
- R8: A step from the all-ones count wraps the count to 0 and sets event status bit 4.
- R9: A read of event status returns the pending bits and clears all of them at that read's edge.
- R10: An event that arrives on the same edge as a clearing read leaves its status bit set.
- R11: irq[k] is high exactly when some status bit of channel k is set and its enable bit (bit 0 for interval, bit 4 for overflow) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_tick | input | NCH | Alternate tick enable, one per channel |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| irq | output | NCH | Per-channel interrupt, level |

## Verification
A write takes effect at the clock edge that samples it. Read data, including a count, reflects register state just before the capture edge and is compared on the following falling edge. An interrupt follows the status register combinationally, so it is checked on the falling edge after the step that sets the status bit. The bench counts every edge since reset: each expected count is derived from the difference between the edge of the zeroing write and the read's capture edge. A status read is issued so that it captures on exactly the edge of an interval event.

// File: rtl/tri_timer_pkg.sv
`timescale 1ns/1ps
package tri_timer_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int NUM_KINDS = 6;

    typedef enum logic [2:0] {
        K_CLKCFG = 3'd0,
        K_RUNCTL = 3'd1,
        K_COUNT  = 3'd2,
        K_LIMIT  = 3'd3,
        K_EVSTAT = 3'd4,
        K_EVMASK = 3'd5,
        K_NONE   = 3'd7
    } reg_kind_e;

    localparam logic [ADDR_W-1:0] BASE_CLKCFG = 8'h00;
    localparam logic [ADDR_W-1:0] BASE_RUNCTL = 8'h0C;
    localparam logic [ADDR_W-1:0] BASE_COUNT  = 8'h18;
    localparam logic [ADDR_W-1:0] BASE_LIMIT  = 8'h24;
    localparam logic [ADDR_W-1:0] BASE_EVSTAT = 8'h54;
    localparam logic [ADDR_W-1:0] BASE_EVMASK = 8'h60;

    // clock config fields
    localparam int CFG_PRE_EN  = 0;
    localparam int CFG_EXP_LSB = 1;
    localparam int EXP_W       = 4;
    localparam int CFG_ALT_SRC = 5;
    localparam int CFG_W       = 6;
    // run control fields
    localparam int CTL_STOP    = 0;
    localparam int CTL_IVL     = 1;
    localparam int CTL_ZERO    = 4;
    // event status / enable fields
    localparam int EV_IVL      = 0;
    localparam int EV_OVF      = 4;

    function automatic logic [ADDR_W-1:0] kind_base(int unsigned idx);
        case (idx)
            0:       return BASE_CLKCFG;
            1:       return BASE_RUNCTL;
            2:       return BASE_COUNT;
            3:       return BASE_LIMIT;
            4:       return BASE_EVSTAT;
            5:       return BASE_EVMASK;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] reg_addr(logic [ADDR_W-1:0] base, int unsigned ch);
        return base + ADDR_W'(4 * ch);
    endfunction
endpackage

// File: rtl/tt_addr_decode.sv
`timescale 1ns/1ps
module tt_addr_decode import tri_timer_pkg::*; #(
    parameter int NCH = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [NCH-1:0]    ch_hit
);
    always_comb begin
        kind   = K_NONE;
        ch_hit = '0;
        for (int unsigned b = 0; b < NUM_KINDS; b++) begin
            for (int unsigned c = 0; c < NCH; c++) begin
                if (addr == reg_addr(kind_base(b), c)) begin
                    kind      = reg_kind_e'(3'(b));
                    ch_hit[c] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tt_prescale.sv
`timescale 1ns/1ps
module tt_prescale import tri_timer_pkg::*; #(
    parameter int EXPW = EXP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_tick,
    input  logic            alt_src,
    input  logic            pre_en,
    input  logic [EXPW-1:0] exp_sel,
    input  logic            run,
    input  logic            clear,
    output logic            step
);
    localparam int PHW = 1 << EXPW;

    typedef struct packed {
        logic [PHW-1:0] phase;
    } ps_state_t;

    ps_state_t      d, q;
    logic           tick;
    logic [PHW-1:0] span;
    logic           terminal;

    always_comb begin
        d        = q;
        tick     = alt_src ? ext_tick : 1'b1;
        // low N+1 bits set: divide by 2^(N+1)
        span     = ~({PHW{1'b1}} << ({1'b0, exp_sel} + 1'b1));
        terminal = (q.phase & span) == span;
        step     = run && tick && (!pre_en || terminal);
        if (clear) begin
            d.phase = '0;
        end else if (run && tick && pre_en) begin
            d.phase = terminal ? '0 : q.phase + PHW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tt_channel.sv
`timescale 1ns/1ps
module tt_channel import tri_timer_pkg::*; #(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  reg_kind_e         kind,
    input  logic              we,
    input  logic              re,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_tick,
    output logic [DATA_W-1:0] rd_val,
    output logic [CW-1:0]     cnt_o,
    output logic [1:0]        ctl_o,
    output logic [1:0]        ev_o,
    output logic [1:0]        mask_o,
    output logic              irq
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             stop;
        logic             ivl_mode;
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    lim;
        logic             ev_ivl;
        logic             ev_ovf;
        logic             en_ivl;
        logic             en_ovf;
    } ch_state_t;

    ch_state_t d, q;
    logic wr, zero_req, ps_clear, step;
    logic rd_clear, hit_lim, at_top, new_ivl, new_ovf;
    logic unused_wdata;

    assign unused_wdata = ^wdata;
    assign wr       = we && sel;
    assign zero_req = wr && (kind == K_RUNCTL) && wdata[CTL_ZERO];
    assign ps_clear = zero_req || (wr && (kind == K_CLKCFG));

    tt_prescale #(.EXPW(EXP_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_tick (ext_tick),
        .alt_src  (q.cfg[CFG_ALT_SRC]),
        .pre_en   (q.cfg[CFG_PRE_EN]),
        .exp_sel  (q.cfg[CFG_EXP_LSB +: EXP_W]),
        .run      (!q.stop),
        .clear    (ps_clear),
        .step     (step)
    );

    always_comb begin
        d        = q;
        new_ivl  = 1'b0;
        new_ovf  = 1'b0;
        hit_lim  = q.ivl_mode && (q.cnt == q.lim);
        at_top   = &q.cnt;
        rd_clear = re && sel && (kind == K_EVSTAT);

        if (step) begin
            if (hit_lim) begin
                d.cnt   = '0;
                new_ivl = 1'b1;
            end else begin
                d.cnt   = q.cnt + CW'(1);
                new_ovf = at_top;
            end
        end

        if (wr) begin
            case (kind)
                K_CLKCFG: d.cfg = wdata[CFG_W-1:0];
                K_RUNCTL: begin
                    d.stop     = wdata[CTL_STOP];
                    d.ivl_mode = wdata[CTL_IVL];
                    if (wdata[CTL_ZERO]) d.cnt = '0;
                end
                K_LIMIT:  d.lim = wdata[CW-1:0];
                K_EVMASK: begin
                    d.en_ivl = wdata[EV_IVL];
                    d.en_ovf = wdata[EV_OVF];
                end
                default: ;
            endcase
        end

        // a fresh event wins over a clearing read on the same edge
        d.ev_ivl = (q.ev_ivl && !rd_clear) || new_ivl;
        d.ev_ovf = (q.ev_ovf && !rd_clear) || new_ovf;

        rd_val = '0;
        case (kind)
            K_CLKCFG: rd_val = DATA_W'(q.cfg);
            K_RUNCTL: rd_val = DATA_W'({q.ivl_mode, q.stop});
            K_COUNT:  rd_val = DATA_W'(q.cnt);
            K_LIMIT:  rd_val = DATA_W'(q.lim);
            K_EVSTAT: begin
                rd_val[EV_IVL] = q.ev_ivl;
                rd_val[EV_OVF] = q.ev_ovf;
            end
            K_EVMASK: begin
                rd_val[EV_IVL] = q.en_ivl;
                rd_val[EV_OVF] = q.en_ovf;
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.stop <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cnt_o  = q.cnt;
    assign ctl_o  = {q.ivl_mode, q.stop};
    assign ev_o   = {q.ev_ovf, q.ev_ivl};
    assign mask_o = {q.en_ovf, q.en_ivl};
    assign irq    = (q.ev_ivl && q.en_ivl) || (q.ev_ovf && q.en_ovf);
endmodule

// File: rtl/tri_timer.sv
`timescale 1ns/1ps
module tri_timer import tri_timer_pkg::*; #(
    parameter int NCH = 3,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ext_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    reg_kind_e                    kind;
    logic [NCH-1:0]               hit;
    logic [NCH-1:0][DATA_W-1:0]   rd_val;
    logic [NCH-1:0][CW-1:0]       cnt_all;
    logic [NCH-1:0][1:0]          ctl_all;
    logic [NCH-1:0][1:0]          ev_all;
    logic [NCH-1:0][1:0]          mask_all;
    logic [DATA_W-1:0]            rd_mux;
    top_state_t                   d, q;

    tt_addr_decode #(.NCH(NCH)) u_dec (
        .addr   (bus_addr),
        .kind   (kind),
        .ch_hit (hit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tt_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (hit[g]),
            .kind     (kind),
            .we       (bus_we),
            .re       (bus_re),
            .wdata    (bus_wdata),
            .ext_tick (ext_tick[g]),
            .rd_val   (rd_val[g]),
            .cnt_o    (cnt_all[g]),
            .ctl_o    (ctl_all[g]),
            .ev_o     (ev_all[g]),
            .mask_o   (mask_all[g]),
            .irq      (irq[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCH; c++) begin
            if (hit[c]) rd_mux = rd_mux | rd_val[c];
        end
        d = q;
        if (bus_re) d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
endmodule

// File: rtl/tri_timer_chk.sv
`timescale 1ns/1ps
module tri_timer_chk import tri_timer_pkg::*; #(
    parameter int NCH = 3,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic                   bus_re,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0][CW-1:0] cnt_all,
    input logic [NCH-1:0][1:0]    ctl_all,
    input logic [NCH-1:0][1:0]    ev_all,
    input logic [NCH-1:0][1:0]    mask_all
);
    logic unused_wbits;
    assign unused_wbits = ^bus_wdata;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq == '0));

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    for (genvar k = 0; k < NCH; k++) begin : g_k
        assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_all[k][0] && !bus_we) |=> (cnt_all[k] == $past(cnt_all[k])));

        assert_zero_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == reg_addr(BASE_RUNCTL, k) && bus_wdata[CTL_ZERO])
            |=> (cnt_all[k] == '0));

        assert_interval_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ev_all[k][0]) |-> (cnt_all[k] == '0));

        assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_re && !bus_we && ctl_all[k][0] && bus_addr == reg_addr(BASE_EVSTAT, k))
            |=> (ev_all[k] == 2'b00));

        assert_masked_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_all[k] == 2'b00) |-> !irq[k]);
    end
endmodule

bind tri_timer tri_timer_chk #(.NCH(NCH), .CW(CW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .cnt_all   (cnt_all),
    .ctl_all   (ctl_all),
    .ev_all    (ev_all),
    .mask_all  (mask_all)
);

// File: tb/test_tri_timer.sv
`timescale 1ns/1ps
module test_tri_timer;
    import tri_timer_pkg::*;

    localparam int NCH = 3;
    localparam int CW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    ext_tick = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NCH-1:0]    irq;

    tri_timer #(.NCH(NCH), .CW(CW)) i_tri_timer (
        .clk, .rst_n, .ext_tick, .bus_addr, .bus_we, .bus_re,
        .bus_wdata, .bus_rdata, .irq
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    int    w_edge = 0;
    bit    done  = 0;
    logic  rd_cap = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) rd_cap <= bus_re;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per captured read
    always @(negedge clk) begin
        if (rd_cap) begin
            if (sbq.size() == 0) begin
                check("R2 unexpected read data", bus_rdata, 32'hDEAD_0000);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    // all tasks start and end on a falling edge
    task automatic wr(logic [7:0] a, logic [31:0] v);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        w_edge = cyc + 1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ad(logic [7:0] base, int ch);
        return reg_addr(base, ch);
    endfunction

    function automatic logic [31:0] cnt_at(int w, int div);
        return 32'(((cyc - w) / div) % 65536);   // capture edge cyc+1, minus one
    endfunction

    initial begin
        int w;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        check("R1 irq after reset", 32'(irq), 32'h0);
        rd(ad(BASE_RUNCTL, 0), 32'h01, "R1 run control reset");
        rd(ad(BASE_COUNT, 0),  32'h00, "R1 count reset");
        rd(ad(BASE_CLKCFG, 2), 32'h00, "R1 clock config reset");
        rd(ad(BASE_EVSTAT, 1), 32'h00, "R1 status reset");

        // R3 free count, then hold
        wr(ad(BASE_RUNCTL, 0), 32'h10);
        w = w_edge;
        idle(7);
        rd(ad(BASE_COUNT, 0), cnt_at(w, 1), "R3 free count");
        wr(ad(BASE_RUNCTL, 0), 32'h01);
        begin
            int held;
            held = w_edge - w;
            idle(5);
            rd(ad(BASE_COUNT, 0), 32'(held), "R3 stopped count holds");
        end

        // R4 zero bit
        wr(ad(BASE_RUNCTL, 0), 32'h11);
        rd(ad(BASE_COUNT, 0),  32'h00, "R4 count zeroed");
        rd(ad(BASE_RUNCTL, 0), 32'h01, "R4 zero bit reads 0");

        // R5 prescaler N=1 -> divide by 4
        wr(ad(BASE_CLKCFG, 1), 32'h03);
        wr(ad(BASE_RUNCTL, 1), 32'h10);
        w = w_edge;
        idle(13);
        rd(ad(BASE_COUNT, 1), cnt_at(w, 4), "R5 prescaled count");
        idle(2);
        rd(ad(BASE_COUNT, 1), cnt_at(w, 4), "R5 prescaled count later");

        // R6 alternate tick source: exactly three ticks
        wr(ad(BASE_CLKCFG, 2), 32'h20);
        wr(ad(BASE_RUNCTL, 2), 32'h10);
        ext_tick[2] = 1'b1;
        idle(3);
        ext_tick[2] = 1'b0;
        idle(4);
        rd(ad(BASE_COUNT, 2), 32'd3, "R6 external ticks counted");

        // R7 / R11 interval mode, limit 5
        wr(ad(BASE_CLKCFG, 1), 32'h00);
        wr(ad(BASE_LIMIT, 1),  32'd5);
        wr(ad(BASE_EVMASK, 1), 32'h01);
        wr(ad(BASE_RUNCTL, 1), 32'h12);
        w = w_edge;
        idle(5);
        check("R7 irq low before limit step", 32'(irq[1]), 32'h0);
        idle(1);
        check("R11 irq high at interval event", 32'(irq[1]), 32'h1);
        idle(8);
        rd(ad(BASE_COUNT, 1), 32'(((cyc - w)) % 6), "R7 count wraps at limit");

        // R9 clearing read on a stopped channel
        wr(ad(BASE_RUNCTL, 1), 32'h03);
        rd(ad(BASE_EVSTAT, 1), 32'h01, "R9 pending interval bit");
        check("R9 irq low after clearing read", 32'(irq[1]), 32'h0);
        rd(ad(BASE_EVSTAT, 1), 32'h00, "R9 status cleared");

        // R10 read landing on the event edge
        wr(ad(BASE_RUNCTL, 1), 32'h12);
        idle(5);
        rd(ad(BASE_EVSTAT, 1), 32'h00, "R10 read on event edge");
        wr(ad(BASE_RUNCTL, 1), 32'h03);
        rd(ad(BASE_EVSTAT, 1), 32'h01, "R10 coincident event kept");

        // R8 / R11 overflow on channel 0, masked then unmasked
        wr(ad(BASE_EVMASK, 0), 32'h00);
        wr(ad(BASE_RUNCTL, 0), 32'h10);
        w = w_edge;
        idle(65536);
        check("R11 masked overflow keeps irq low", 32'(irq[0]), 32'h0);
        wr(ad(BASE_EVMASK, 0), 32'h10);
        check("R11 enabling overflow raises irq", 32'(irq[0]), 32'h1);
        rd(ad(BASE_COUNT, 0), cnt_at(w, 1), "R8 count wrapped");
        rd(ad(BASE_EVSTAT, 0), 32'h10, "R8 overflow bit");
        check("R9 irq low after overflow read", 32'(irq[0]), 32'h0);

        // R2 stride, read-only count, unmapped address
        wr(ad(BASE_LIMIT, 2), 32'h1234);
        rd(8'h2C, 32'h1234, "R2 channel 2 limit at 0x2C");
        rd(8'h28, 32'd5,    "R2 channel 1 limit at 0x28");
        rd(8'h24, 32'h0,    "R2 channel 0 limit at 0x24");
        wr(ad(BASE_COUNT, 1), 32'hBEEF);
        rd(ad(BASE_COUNT, 1), 32'd1, "R2 count is read-only");
        rd(8'h40, 32'h0, "R2 unmapped reads zero");

        idle(2);
        if (sbq.size() != 0) check("R2 reads left unanswered", 32'(sbq.size()), 32'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule